// File: doc/BRIEF.md
# Three-Channel Programmable Interval Timer

This block holds three independent 16-bit down-counters behind an 8-bit register port with four addresses. Addresses 0 to 2 reach the data port of counters 0 to 2. Address 3 takes a control word. Each counter has a gate input, a count-enable input and an output line. A counter advances on a clock edge only when its gate and its count enable are both high. The output of counter 0 is also given as a registered `irq0` for an edge-triggered interrupt input.

A control word picks a counter, a byte-access order and a counting mode, or it freezes the counter's current value for reading. A counter stays idle after it is programmed until its whole reload value has arrived. Modes 0 and 1 count down once to a sticky high output. Mode 2 gives a periodic pulse. Mode 3 gives a square wave by counting down two per tick. The register port is plain strobed control: a write or read takes effect on the rising edge where `wr_en` or `rd_en` is high, and `rdata` is combinational from `addr`. It has no valid/ready handshake because it never applies back-pressure.

Top module: `tri_interval_timer`

## Requirements
- R1: After reset all three outputs and `irq0` are low, every counter is halted in mode 0 with low-then-high access, and a counter reads as zero.
- R2: Control-word bits 7:6 select counter 0, 1 or 2. The value 3 is ignored and leaves every counter, output and access state unchanged.
- R3: Writing a control word whose bits 5:4 are nonzero drives the output low for modes 0 and 1, and high for modes 2 and 3. The counter then stays halted until its reload value is complete. In low-then-high access (bits 5:4 = 11), the first data write stores the low byte and keeps the counter halted. The second write stores the high byte, loads the counter and starts it.
- R4: With bits 5:4 = 01, one data write replaces only the low byte of the reload value and loads the counter. With 10, one write replaces only the high byte. The other byte keeps its earlier value.
- R5: In mode 0 the count drops by one per tick. The output rises on the tick that takes the count from 1 to 0, that is N ticks after reload N is loaded. It stays high until the counter is reprogrammed.
- R6: In mode 2 with reload N ≥ 2, the output is low for exactly one tick per N-tick period: after the (N-1)th tick of each period. It then returns high as the count reloads.
- R7: In mode 3 the load clears bit 0 and the count drops by two per tick. The output toggles when the count reaches terminal count. A high phase reloads the full value and a low phase reloads it with bit 0 cleared. The first high phase lasts N>>1 ticks, every low phase N>>1 ticks, and every later high phase (N+1)>>1 ticks.
- R8: On a clock where a counter's gate or count enable is low, its count does not change.
- R9: With no latch pending, a data read returns the live count. Access 01 always gives the low byte, 10 always the high byte, and 11 alternates low then high, starting with low after programming.
- R10: A control word with bits 5:4 = 00 freezes the selected counter's value for reading until all of its bytes have been read. A further latch command while one is pending is ignored.
- R11: `irq0` equals counter 0's output delayed by one clock.
- R12: Mode fields 6 and 7 behave as modes 2 and 3. Mode 1 and the fields 4 and 5 behave as modes 0 and 1 (no hardware trigger). Bit 0 is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write strobe for the register port |
| rd_en | input | 1 | Read strobe; advances the byte order at the clock edge |
| addr | input | 2 | 0–2 counter data port, 3 control word |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for `addr` (0 at address 3) |
| gate | input | 3 | Per-counter gate, high lets it count |
| cnt_en | input | 3 | Per-counter count-clock enable |
| tmr_out | output | 3 | Per-counter output line |
| irq0 | output | 1 | Registered copy of counter 0's output |

## Verification
The assertions assume that `wr_en` and `rd_en` are never high in the same cycle. They also assume that a control word and a data write never target the same counter at once, and that every strobe is a clean level held for one clock. The bench drives every access from a task that raises a single strobe for exactly one cycle, and changes gate and count-enable levels only between accesses. Mode 2 is always run with reloads of 2 or more, which keeps the stimulus inside the range where the pulse rule applies.

// File: rtl/pit_pkg.sv
package pit_pkg;
  typedef enum logic [1:0] {
    ACC_LATCH = 2'd0,
    ACC_LO    = 2'd1,
    ACC_HI    = 2'd2,
    ACC_WORD  = 2'd3
  } acc_e;

  typedef enum logic [1:0] {
    MD_ONESHOT = 2'd0,
    MD_TRIG    = 2'd1,
    MD_RATE    = 2'd2,
    MD_SQUARE  = 2'd3
  } mode_e;

  // fields 4..7 fold onto 0..3
  function automatic mode_e fold_mode(input logic [2:0] field);
    return mode_e'(field[1:0]);
  endfunction

  function automatic logic starts_high(input mode_e m);
    return (m == MD_RATE) || (m == MD_SQUARE);
  endfunction
endpackage

// File: rtl/timer_port_ctl.sv
module timer_port_ctl
  import pit_pkg::*;
#(
  parameter int DATA_W = 8,
  localparam int CNT_W = 2 * DATA_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              prog_i,
  input  acc_e              acc_i,
  input  logic              latch_cmd_i,
  input  logic              data_wr_i,
  input  logic              data_rd_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [CNT_W-1:0]  count_i,
  output logic [CNT_W-1:0]  reload_o,
  output logic              load_o,
  output logic              halt_o,
  output logic [DATA_W-1:0] rdata_o
);
  acc_e             acc_q;
  logic             wr_hi_q, rd_hi_q, latched_q;
  logic [CNT_W-1:0] latch_q, reload_q, reload_nxt, rd_src;
  logic             rd_high, rd_done;

  always_comb begin
    reload_nxt = reload_q;
    load_o     = 1'b0;
    halt_o     = 1'b0;
    if (data_wr_i) begin
      unique case (acc_q)
        ACC_LO: begin
          reload_nxt[DATA_W-1:0] = wdata_i;
          load_o = 1'b1;
        end
        ACC_HI: begin
          reload_nxt[CNT_W-1:DATA_W] = wdata_i;
          load_o = 1'b1;
        end
        default: begin
          if (wr_hi_q) begin
            reload_nxt[CNT_W-1:DATA_W] = wdata_i;
            load_o = 1'b1;
          end else begin
            reload_nxt[DATA_W-1:0] = wdata_i;
            halt_o = 1'b1;
          end
        end
      endcase
    end
  end

  assign reload_o = reload_nxt;
  assign rd_src   = latched_q ? latch_q : count_i;
  assign rd_high  = (acc_q == ACC_HI) || ((acc_q == ACC_WORD) && rd_hi_q);
  assign rd_done  = (acc_q != ACC_WORD) || rd_hi_q;
  assign rdata_o  = rd_high ? rd_src[CNT_W-1:DATA_W] : rd_src[DATA_W-1:0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      acc_q     <= ACC_WORD;
      wr_hi_q   <= 1'b0;
      rd_hi_q   <= 1'b0;
      latched_q <= 1'b0;
      latch_q   <= '0;
      reload_q  <= '0;
    end else begin
      reload_q <= reload_nxt;
      if (prog_i) begin
        acc_q     <= acc_i;
        wr_hi_q   <= 1'b0;
        rd_hi_q   <= 1'b0;
        latched_q <= 1'b0;
      end else begin
        if (data_wr_i && acc_q == ACC_WORD) wr_hi_q <= ~wr_hi_q;
        if (data_rd_i) begin
          if (acc_q == ACC_WORD) rd_hi_q <= ~rd_hi_q;
          if (rd_done) latched_q <= 1'b0;
        end else if (latch_cmd_i && !latched_q) begin
          latched_q <= 1'b1;
          latch_q   <= count_i;
        end
      end
    end
  end

  assert_latch_frozen_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (latched_q && !prog_i && !data_rd_i) |=> (latched_q && $stable(latch_q)));
endmodule

// File: rtl/timer_count_core.sv
module timer_count_core
  import pit_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             prog_i,
  input  mode_e            mode_i,
  input  logic             load_i,
  input  logic             halt_i,
  input  logic [CNT_W-1:0] reload_i,
  input  logic             tick_i,
  output logic [CNT_W-1:0] count_o,
  output logic             out_o
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);
  localparam logic [CNT_W-1:0] TWO = CNT_W'(2);

  mode_e            mode_q;
  logic             armed_q, out_q;
  logic [CNT_W-1:0] cnt_q, reload_even;

  assign reload_even = {reload_i[CNT_W-1:1], 1'b0};
  assign count_o     = cnt_q;
  assign out_o       = out_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_q  <= MD_ONESHOT;
      armed_q <= 1'b0;
      cnt_q   <= '0;
      out_q   <= 1'b0;
    end else if (prog_i) begin
      mode_q  <= mode_i;
      armed_q <= 1'b0;
      out_q   <= starts_high(mode_i);
    end else if (load_i) begin
      armed_q <= 1'b1;
      cnt_q   <= (mode_q == MD_SQUARE) ? reload_even : reload_i;
    end else if (halt_i) begin
      armed_q <= 1'b0;
    end else if (armed_q && tick_i) begin
      unique case (mode_q)
        MD_RATE: begin
          if (cnt_q == TWO) begin
            out_q <= 1'b0;
            cnt_q <= ONE;
          end else if (cnt_q == ONE) begin
            out_q <= 1'b1;
            cnt_q <= reload_i;
          end else begin
            cnt_q <= cnt_q - ONE;
          end
        end
        MD_SQUARE: begin
          if (cnt_q != '0 && cnt_q <= TWO) begin
            out_q <= ~out_q;
            cnt_q <= out_q ? reload_even : reload_i;
          end else begin
            cnt_q <= cnt_q - TWO;
          end
        end
        default: begin
          if (cnt_q == ONE) out_q <= 1'b1;
          cnt_q <= cnt_q - ONE;
        end
      endcase
    end
  end

  assert_halted_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!armed_q && !load_i) |=> $stable(cnt_q));
  assert_no_tick_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick_i && !load_i) |=> $stable(cnt_q));
  assert_sticky_out_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ((mode_q == MD_ONESHOT || mode_q == MD_TRIG) && out_q && !prog_i) |=> out_q);
  assert_prog_level_R3: assert property (@(posedge clk) disable iff (!rst_n)
    prog_i |=> (out_q == ($past(mode_i) == MD_RATE || $past(mode_i) == MD_SQUARE)));
  assert_even_load_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (load_i && !prog_i && mode_q == MD_SQUARE) |=> !cnt_q[0]);
endmodule

// File: rtl/tri_interval_timer.sv
module tri_interval_timer
  import pit_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [1:0]        addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  input  logic [2:0]        gate,
  input  logic [2:0]        cnt_en,
  output logic [2:0]        tmr_out,
  output logic              irq0
);
  localparam int N_CH  = 3;
  localparam int CNT_W = 2 * DATA_W;
  localparam logic [1:0] CTRL_ADDR = 2'd3;

  logic              ctrl_wr;
  logic [1:0]        sel;
  acc_e              acc_f;
  mode_e             mode_f;
  logic [DATA_W-1:0] ch_rdata [N_CH];
  logic              irq0_q;

  assign ctrl_wr = wr_en && (addr == CTRL_ADDR);
  assign sel     = wdata[7:6];
  assign acc_f   = acc_e'(wdata[5:4]);
  assign mode_f  = fold_mode(wdata[3:1]);

  for (genvar i = 0; i < N_CH; i++) begin : g_ch
    logic             sel_me, prog, latch_cmd, dwr, drd, load, halt;
    logic [CNT_W-1:0] reload, count;

    assign sel_me    = ctrl_wr && (sel == 2'(i));
    assign prog      = sel_me && (acc_f != ACC_LATCH);
    assign latch_cmd = sel_me && (acc_f == ACC_LATCH);
    assign dwr       = wr_en && (addr == 2'(i));
    assign drd       = rd_en && (addr == 2'(i));

    timer_port_ctl #(.DATA_W(DATA_W)) u_port (
      .clk(clk), .rst_n(rst_n), .prog_i(prog), .acc_i(acc_f),
      .latch_cmd_i(latch_cmd), .data_wr_i(dwr), .data_rd_i(drd),
      .wdata_i(wdata), .count_i(count), .reload_o(reload),
      .load_o(load), .halt_o(halt), .rdata_o(ch_rdata[i])
    );

    timer_count_core #(.CNT_W(CNT_W)) u_core (
      .clk(clk), .rst_n(rst_n), .prog_i(prog), .mode_i(mode_f),
      .load_i(load), .halt_i(halt), .reload_i(reload),
      .tick_i(gate[i] && cnt_en[i]), .count_o(count), .out_o(tmr_out[i])
    );
  end

  always_comb begin
    rdata = '0;
    for (int i = 0; i < N_CH; i++)
      if (addr == 2'(i)) rdata = ch_rdata[i];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) irq0_q <= 1'b0;
    else        irq0_q <= tmr_out[0];
  end
  assign irq0 = irq0_q;

  assert_ctrl3_inert_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_wr && sel == 2'd3) |=> $stable(tmr_out));
  assert_irq_rises_after_out_R11: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq0) |-> $past(tmr_out[0]));
endmodule

// File: tb/sim_tri_interval_timer.sv
module sim_tri_interval_timer;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0, rd_en = 1'b0;
  logic [1:0] addr = 2'd0;
  logic [7:0] wdata = 8'd0;
  logic [7:0] rdata;
  logic [2:0] gate = 3'b111, cnt_en = 3'b111;
  logic [2:0] tmr_out;
  logic       irq0;

  int n_cmp = 0, n_bad = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  tri_interval_timer u0 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .gate(gate), .cnt_en(cnt_en),
    .tmr_out(tmr_out), .irq0(irq0)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    rd_en = 1'b1; addr = a;
    #1 d = rdata;
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    logic [7:0] b;
    logic [2:0] snap;
    idle(3);
    rst_n = 1'b1;
    idle(1);
    // R1 reset state
    chk("R1 outputs", int'(tmr_out), 0);
    chk("R1 irq0", int'(irq0), 0);
    rd(2'd0, b); chk("R1 count reads zero", b, 0);
    idle(2);
    chk("R1 halted output", int'(tmr_out), 0);

    // R5 / R11 mode 0 sweep on counter 0 (control 0x30: ch0, word access, mode 0)
    for (int n = 1; n <= 8; n++) begin
      wr(2'd3, 8'h30);
      chk("R3 mode0 prog low", int'(tmr_out[0]), 0);
      wr(2'd0, 8'(n));
      wr(2'd0, 8'h00);
      idle(n - 1);
      chk("R5 before terminal", int'(tmr_out[0]), 0);
      idle(1);
      chk("R5 at terminal", int'(tmr_out[0]), 1);
      chk("R11 irq0 lags", int'(irq0), 0);
      idle(1);
      chk("R11 irq0 follows", int'(irq0), 1);
      idle(3);
      chk("R5 sticky", int'(tmr_out[0]), 1);
    end

    // R3 halt between the two bytes
    wr(2'd3, 8'h30);
    wr(2'd0, 8'h01);
    idle(5);
    chk("R3 halted after low byte", int'(tmr_out[0]), 0);
    wr(2'd0, 8'h00);
    idle(1);
    chk("R3 started after high byte", int'(tmr_out[0]), 1);
    idle(20);
    chk("R5 stays high", int'(tmr_out[0]), 1);

    // R6 mode 2 sweep on counter 1 (0x74)
    for (int n = 2; n <= 7; n++) begin
      wr(2'd3, 8'h74);
      chk("R3 mode2 prog high", int'(tmr_out[1]), 1);
      wr(2'd1, 8'(n));
      wr(2'd1, 8'h00);
      for (int k = 1; k <= 2 * n + 1; k++) begin
        idle(1);
        chk("R6 rate pulse", int'(tmr_out[1]), (k % n == n - 1) ? 0 : 1);
      end
    end

    // R7 mode 3 sweep on counter 2 (0xB6)
    for (int n = 2; n <= 9; n++) begin
      int lvl, rem;
      wr(2'd3, 8'hB6);
      chk("R3 mode3 prog high", int'(tmr_out[2]), 1);
      wr(2'd2, 8'(n));
      wr(2'd2, 8'h00);
      lvl = 1; rem = n >> 1;
      for (int k = 1; k <= 3 * n; k++) begin
        idle(1);
        rem--;
        if (rem == 0) begin
          lvl = 1 - lvl;
          rem = (lvl == 1) ? ((n + 1) >> 1) : (n >> 1);
        end
        chk("R7 square level", int'(tmr_out[2]), lvl);
      end
    end

    // R12 aliases: field 6 -> mode 2, field 7 -> mode 3, mode 1 -> one-shot
    wr(2'd3, 8'h7C);
    chk("R12 field6 high", int'(tmr_out[1]), 1);
    wr(2'd1, 8'd3); wr(2'd1, 8'd0);
    for (int k = 1; k <= 7; k++) begin
      idle(1);
      chk("R12 field6 rate", int'(tmr_out[1]), (k % 3 == 2) ? 0 : 1);
    end
    wr(2'd3, 8'hBE);
    chk("R12 field7 high", int'(tmr_out[2]), 1);
    wr(2'd2, 8'd4); wr(2'd2, 8'd0);
    for (int k = 1; k <= 8; k++) begin
      idle(1);
      chk("R12 field7 square", int'(tmr_out[2]), ((k / 2) % 2 == 0) ? 1 : 0);
    end
    wr(2'd3, 8'h32);
    chk("R12 mode1 low", int'(tmr_out[0]), 0);
    wr(2'd0, 8'd2); wr(2'd0, 8'd0);
    idle(1);
    chk("R12 mode1 counting", int'(tmr_out[0]), 0);
    idle(1);
    chk("R12 mode1 terminal", int'(tmr_out[0]), 1);

    // R8 / R9 gate and enable on counter 1
    gate[1] = 1'b0;
    wr(2'd3, 8'h70);
    wr(2'd1, 8'h34); wr(2'd1, 8'h12);
    idle(10);
    rd(2'd1, b); chk("R8 gate low, low byte", b, 8'h34);
    rd(2'd1, b); chk("R9 word read high byte", b, 8'h12);
    gate[1] = 1'b1; cnt_en[1] = 1'b0;
    idle(5);
    rd(2'd1, b); chk("R8 enable low, low byte", b, 8'h34);
    rd(2'd1, b); chk("R8 enable low, high byte", b, 8'h12);
    cnt_en[1] = 1'b1;
    idle(3);
    rd(2'd1, b); chk("R9 live low byte", b, 8'h31);
    rd(2'd1, b); chk("R9 live high byte", b, 8'h12);

    // R10 latch on counter 1 running mode 2 with reload 1000
    wr(2'd3, 8'h74);
    wr(2'd1, 8'hE8); wr(2'd1, 8'h03);
    wr(2'd3, 8'h40);
    idle(3);
    wr(2'd3, 8'h40);
    idle(2);
    rd(2'd1, b); chk("R10 latched low", b, 8'hE8);
    rd(2'd1, b); chk("R10 latched high, second latch ignored", b, 8'h03);
    rd(2'd1, b); chk("R10 released, live low", b, 8'hDF);
    rd(2'd1, b); chk("R10 released, live high", b, 8'h03);

    // R4 single-byte access on counter 2, gate low
    gate[2] = 1'b0;
    wr(2'd3, 8'h90);
    wr(2'd2, 8'h05);
    rd(2'd2, b); chk("R4 low-only load", b, 8'h05);
    rd(2'd2, b); chk("R9 low-only read repeats", b, 8'h05);
    wr(2'd3, 8'hA0);
    wr(2'd2, 8'h02);
    rd(2'd2, b); chk("R4 high-only load keeps low", b, 8'h02);
    rd(2'd2, b); chk("R9 high-only read repeats", b, 8'h02);
    wr(2'd3, 8'h90);
    rd(2'd2, b); chk("R4 low byte kept after high write", b, 8'h05);
    gate[2] = 1'b1;

    // R2 select value 3 ignored
    idle(2);
    snap = tmr_out;
    wr(2'd3, 8'hD4);
    idle(2);
    chk("R2 select 3 ignored", int'(tmr_out), int'(snap));
    rd(2'd2, b); chk("R2 select 3 leaves access mode", b, 8'h05);

    finish_run();
  end
endmodule